// File: doc/BRIEF.md
# Logic Unit with Byte Reversal

This block is the logical-operation slice of a processor execute stage. It accepts two 64-bit operands, `rs_i` and `rb_i`, a 2-bit operation select and three invert controls, and returns a 64-bit result one clock later. The logic path has a single AND gate array. An invert control on each operand and one on the result give it the whole AND/OR family. OR is built as NOT(NOT a AND NOT b), and the same path also gives NAND, NOR, AND-with-complement and OR-with-complement.

The same unit also reverses byte order at three granularities: inside each 16-bit halfword, inside each 32-bit word, or across the whole 64-bit doubleword. The byte-reverse operations read only `rs_i`.

A single output register holds the result. `valid_o` follows `valid_i` by exactly one clock. The register loads only on cycles where `valid_i` is high, so `result_o` keeps its value between valid issues.

Top module: `logic_brev_unit`

## Requirements
- R1: With `op_i` = 2'b00 (logic), the result is `((rs_i ^ {64{inv_a_i}}) & (rb_i ^ {64{inv_b_i}})) ^ {64{inv_out_i}}`. With no invert control set, this is a plain bitwise AND.
- R2: With `op_i` = 2'b00 and `inv_a_i`, `inv_b_i` and `inv_out_i` all set, the result is the bitwise OR of `rs_i` and `rb_i`.
- R3: With `op_i` = 2'b01, the bytes inside each of the four halfwords of `rs_i` swap places. Output byte k takes input byte k XOR 1, where byte 0 is bits 7:0.
- R4: With `op_i` = 2'b10, the byte order inside each of the two words of `rs_i` is reversed. Output byte k takes input byte k XOR 3.
- R5: With `op_i` = 2'b11, all eight bytes of `rs_i` are reversed. Output byte k takes input byte 7-k.
- R6: In the three byte-reverse modes, `rb_i`, `inv_a_i`, `inv_b_i` and `inv_out_i` have no effect on `result_o`.
- R7: `valid_o` equals `valid_i` one clock earlier. `result_o` takes the operation result computed from the inputs of a cycle with `valid_i` high, and holds its value after a cycle with `valid_i` low.
- R8: While `rst_ni` is low, `valid_o` and `result_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Operation issued this cycle |
| op_i | input | 2 | 00 logic, 01 halfword swap, 10 word swap, 11 doubleword swap |
| inv_a_i | input | 1 | Invert `rs_i` before the AND |
| inv_b_i | input | 1 | Invert `rb_i` before the AND |
| inv_out_i | input | 1 | Invert the AND result |
| rs_i | input | 64 | First operand, and the only source for byte reversal |
| rb_i | input | 64 | Second operand for logic operations |
| valid_o | output | 1 | Result valid, one clock after `valid_i` |
| result_o | output | 64 | Registered result |

## Verification
A wrong byte-select index in one swap network shows up at once as a misplaced byte in `result_o`, one clock after issue. The pattern 0x0102030405060708 makes the misplacement readable, because every byte value is distinct. A wrong invert path shows up as flipped bits in the next registered result for one of the eight invert combinations. The bench walks through all eight combinations on several operand patterns. A fault in the load enable of the output register shows up in the first idle cycle that follows an issue with different inputs. The held result then changes, or `valid_o` no longer lags `valid_i` by exactly one clock.

// File: rtl/lbu_pkg.sv
package lbu_pkg;
  localparam int unsigned DATA_W = 64;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [1:0] {
    OPC_LOGIC = 2'b00,
    OPC_SW16  = 2'b01,
    OPC_SW32  = 2'b10,
    OPC_SW64  = 2'b11
  } opc_e;
endpackage

// File: rtl/lbu_logic_core.sv
module lbu_logic_core #(
  parameter int unsigned WIDTH = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             inv_a_i,
  input  logic             inv_b_i,
  input  logic             inv_out_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] y_o
);
  logic [WIDTH-1:0] a_eff, b_eff, and_res;

  assign a_eff   = a_i ^ {WIDTH{inv_a_i}};
  assign b_eff   = b_i ^ {WIDTH{inv_b_i}};
  assign and_res = a_eff & b_eff;
  // OR family: invert both sides and the output around the AND
  assign y_o     = and_res ^ {WIDTH{inv_out_i}};

  // R1: without output invert, no result bit is set outside the raw operand a
  assert_and_subset_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !inv_a_i && !inv_out_i) |-> ((y_o & ~a_i) == '0));

  // R2: with all inverts the result covers both operands
  assert_or_superset_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && inv_a_i && inv_b_i && inv_out_i) |-> (((a_i | b_i) & ~y_o) == '0));
endmodule

// File: rtl/lbu_byte_swap.sv
module lbu_byte_swap #(
  parameter int unsigned WIDTH  = 64,
  parameter int unsigned BYTE_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       mode_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  import lbu_pkg::*;

  localparam int unsigned NBYTES = WIDTH / BYTE_W;
  localparam int unsigned NGRAN  = 3;

  logic [WIDTH-1:0] swapped [NGRAN];

  // granule of 2, 4 and 8 bytes; byte k takes byte k XOR (granule-1)
  for (genvar g = 0; g < NGRAN; g++) begin : g_gran
    localparam int unsigned GB = 2 << g;
    for (genvar k = 0; k < NBYTES; k++) begin : g_byte
      localparam int unsigned SRC = (k / GB) * GB + (GB - 1 - (k % GB));
      assign swapped[g][k*BYTE_W +: BYTE_W] = d_i[SRC*BYTE_W +: BYTE_W];
    end
  end

  always_comb begin
    unique case (opc_e'(mode_i))
      OPC_SW16: q_o = swapped[0];
      OPC_SW32: q_o = swapped[1];
      OPC_SW64: q_o = swapped[2];
      default:  q_o = d_i;
    endcase
  end

  // a reorder keeps the number of set bits
  assert_pop_sw16_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == OPC_SW16) |-> ($countones(q_o) == $countones(d_i)));
  assert_pop_sw32_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == OPC_SW32) |-> ($countones(q_o) == $countones(d_i)));
  assert_ends_sw64_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == OPC_SW64) |-> (q_o[BYTE_W-1:0] == d_i[WIDTH-1 -: BYTE_W]));
endmodule

// File: rtl/logic_brev_unit.sv
module logic_brev_unit #(
  parameter int unsigned DATA_W = lbu_pkg::DATA_W,
  parameter int unsigned BYTE_W = lbu_pkg::BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [1:0]        op_i,
  input  logic              inv_a_i,
  input  logic              inv_b_i,
  input  logic              inv_out_i,
  input  logic [DATA_W-1:0] rs_i,
  input  logic [DATA_W-1:0] rb_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] result_o
);
  import lbu_pkg::*;

  logic              is_logic;
  logic [DATA_W-1:0] logic_res, swap_res, result_d;
  logic              armed_q;

  assign is_logic = (op_i == OPC_LOGIC);

  lbu_logic_core #(.WIDTH(DATA_W)) u_logic (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (is_logic),
    .inv_a_i   (inv_a_i),
    .inv_b_i   (inv_b_i),
    .inv_out_i (inv_out_i),
    .a_i       (rs_i),
    .b_i       (rb_i),
    .y_o       (logic_res)
  );

  lbu_byte_swap #(.WIDTH(DATA_W), .BYTE_W(BYTE_W)) u_swap (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .mode_i (op_i),
    .d_i    (rs_i),
    .q_o    (swap_res)
  );

  assign result_d = is_logic ? logic_res : swap_res;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      result_o <= '0;
      armed_q  <= 1'b0;
    end else begin
      valid_o  <= valid_i;
      armed_q  <= 1'b1;
      if (valid_i) result_o <= result_d;
    end
  end

  assert_valid_follow_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q |-> (valid_o == $past(valid_i)));
  assert_hold_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && !$past(valid_i)) |-> $stable(result_o));
  // R6: byte reversal output depends on rs_i and op_i only
  assert_rb_ignored_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && !is_logic && $stable(rs_i) && $stable(op_i)) |-> $stable(result_d));
endmodule

// File: tb/logic_brev_unit_tb_top.sv
`timescale 1ns/1ps
module logic_brev_unit_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [1:0]  op_i = 2'b00;
  logic        inv_a_i = 1'b0, inv_b_i = 1'b0, inv_out_i = 1'b0;
  logic [63:0] rs_i = '0, rb_i = '0;
  logic        valid_o;
  logic [63:0] result_o;

  int n_cmp = 0;
  int n_bad = 0;
  logic done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  logic_brev_unit dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i),
    .inv_a_i(inv_a_i), .inv_b_i(inv_b_i), .inv_out_i(inv_out_i),
    .rs_i(rs_i), .rb_i(rb_i), .valid_o(valid_o), .result_o(result_o)
  );

  localparam logic [63:0] PAT_SEQ  = 64'h0102030405060708;
  localparam logic [63:0] PAT_ZERO = 64'h0;
  localparam logic [63:0] PAT_ONES = 64'hFFFF_FFFF_FFFF_FFFF;

  function automatic logic [63:0] ref_logic(logic [63:0] a, logic [63:0] b,
                                            logic ia, logic ib, logic io);
    logic [63:0] x;
    x = (ia ? ~a : a) & (ib ? ~b : b);
    return io ? ~x : x;
  endfunction

  function automatic logic [63:0] ref_swap(logic [63:0] d, int gb);
    logic [63:0] r;
    for (int k = 0; k < 8; k++) r[k*8 +: 8] = d[((k / gb) * gb + gb - 1 - (k % gb))*8 +: 8];
    return r;
  endfunction

  function automatic logic [63:0] rnd64();
    return {$urandom(), $urandom()};
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive at negedge, sample just after the capturing edge
  task automatic issue(logic [1:0] op, logic ia, logic ib, logic io,
                       logic [63:0] a, logic [63:0] b);
    @(negedge clk_i);
    valid_i = 1'b1; op_i = op; inv_a_i = ia; inv_b_i = ib; inv_out_i = io;
    rs_i = a; rb_i = b;
    @(posedge clk_i); #1;
    valid_i = 1'b0;
  endtask

  task automatic t_reset();
    #1;
    check("R8 valid_o in reset", {63'b0, valid_o}, 64'd0);
    check("R8 result_o in reset", result_o, 64'd0);
    repeat (3) @(posedge clk_i);
    @(negedge clk_i) rst_ni = 1'b1;
    @(posedge clk_i); #1;
    check("R8 valid_o after reset", {63'b0, valid_o}, 64'd0);
  endtask

  task automatic t_logic_grid();
    logic [63:0] pa [4];
    logic [63:0] pb [4];
    pa[0] = PAT_SEQ; pa[1] = PAT_ZERO; pa[2] = PAT_ONES; pa[3] = rnd64();
    pb[0] = rnd64(); pb[1] = PAT_ONES; pb[2] = PAT_SEQ;  pb[3] = rnd64();
    for (int p = 0; p < 4; p++) begin
      for (int c = 0; c < 8; c++) begin
        issue(2'b00, c[2], c[1], c[0], pa[p], pb[p]);
        check("R1 logic combo", result_o, ref_logic(pa[p], pb[p], c[2], c[1], c[0]));
        check("R7 valid_o after issue", {63'b0, valid_o}, 64'd1);
      end
    end
    issue(2'b00, 1'b0, 1'b0, 1'b0, 64'hF0F0_0000_FFFF_1234, 64'hFF00_FF00_0F0F_00FF);
    check("R1 plain AND", result_o, 64'hF000_0000_0F0F_0034);
  endtask

  task automatic t_or();
    issue(2'b00, 1'b1, 1'b1, 1'b1, 64'hF0F0_0000_FFFF_1200, 64'h0F00_0001_0000_0034);
    check("R2 OR const", result_o, 64'hFFF0_0001_FFFF_1234);
    for (int i = 0; i < 16; i++) begin
      logic [63:0] a, b;
      a = rnd64(); b = rnd64();
      issue(2'b00, 1'b1, 1'b1, 1'b1, a, b);
      check("R2 OR random", result_o, a | b);
    end
  endtask

  task automatic t_swap(logic [1:0] op, int gb, string req, logic [63:0] seq_exp);
    issue(op, 1'b0, 1'b0, 1'b0, PAT_SEQ, PAT_ZERO);
    check(req, result_o, seq_exp);
    issue(op, 1'b0, 1'b0, 1'b0, PAT_ZERO, rnd64());
    check(req, result_o, PAT_ZERO);
    issue(op, 1'b0, 1'b0, 1'b0, PAT_ONES, rnd64());
    check(req, result_o, PAT_ONES);
    for (int i = 0; i < 12; i++) begin
      logic [63:0] a;
      a = rnd64();
      issue(op, 1'b0, 1'b0, 1'b0, a, rnd64());
      check(req, result_o, ref_swap(a, gb));
    end
  endtask

  task automatic t_swap_ignore();
    for (int m = 1; m < 4; m++) begin
      for (int c = 0; c < 8; c++) begin
        logic [63:0] a;
        a = rnd64();
        issue(m[1:0], c[2], c[1], c[0], a, rnd64());
        check("R6 controls and rb ignored", result_o, ref_swap(a, 1 << m));
      end
    end
  endtask

  task automatic t_valid_hold();
    logic [63:0] a, b, held;
    a = rnd64(); b = rnd64();
    issue(2'b00, 1'b0, 1'b1, 1'b0, a, b);
    held = ref_logic(a, b, 1'b0, 1'b1, 1'b0);
    check("R7 captured", result_o, held);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk_i);
      valid_i = 1'b0; op_i = i[1:0]; rs_i = rnd64(); rb_i = rnd64();
      inv_a_i = ~inv_a_i; inv_out_i = ~inv_out_i;
      @(posedge clk_i); #1;
      check("R7 hold when idle", result_o, held);
      check("R7 valid_o low", {63'b0, valid_o}, 64'd0);
    end
    issue(2'b11, 1'b0, 1'b0, 1'b0, PAT_SEQ, PAT_ONES);
    @(negedge clk_i);
    check("R7 back-to-back value", result_o, ref_swap(PAT_SEQ, 8));
    issue(2'b01, 1'b0, 1'b0, 1'b0, PAT_SEQ, PAT_ONES);
    check("R7 next issue", result_o, 64'h0201040306050807);
  endtask

  initial begin
    t_reset();
    t_logic_grid();
    t_or();
    t_swap(2'b01, 2, "R3 halfword swap", 64'h0201040306050807);
    t_swap(2'b10, 4, "R4 word swap",     64'h0403020108070605);
    t_swap(2'b11, 8, "R5 dword swap",    64'h0807060504030201);
    t_swap_ignore();
    t_valid_hold();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule